// File: doc/BRIEF.md
# Selectable Clock Output Divider

This block produces one divided clock output from either of two reference clocks: a 32768 Hz low-frequency clock or a high-frequency clock of roughly 4 MHz. Both references are treated as asynchronous. Each one passes through a short synchronizer into the block's own clock domain. Every rising and every falling edge of the selected reference counts as one event. The output toggles after a programmed number of events, so its frequency is the reference frequency divided by the total ratio, with a 50% duty cycle.

An 8-bit control register, written through a simple write port and always readable, holds the settings. These are an output enable, a power-of-two post-divider code, the reference select, and a pre-divider code that applies only on the high-frequency path. The pre-divider table is not uniform: codes 0 to 6 give powers of two up to 64, and the top code gives 122. A change to the divider codes or to the reference select is held back until the output next falls. Only then does it reach the counters. Every high phase therefore runs its full length, and switching between the two references leaves no runt pulse.

Top module: `clkout_divider`

## Requirements
- R1: The control register reads back on `cfg_rdata` exactly as last written, from the cycle after the write. Its fields are: enable in bit 0, post-divider code in bits 3:1, reference select in bit 4, pre-divider code in bits 7:5.
- R2: While `rst_n` is low at a clock edge, the register, the counters and the synchronizers clear. After that edge, `clk_out` and `cfg_rdata` are 0.
- R3: Select value 0 chooses `lf_clk_i` and value 1 chooses `hf_clk_i`. Each edge of the selected reference is one event, taken through a two-stage synchronizer. A change on the reference input before clock edge k can toggle `clk_out` at edge k+2 at the earliest. `clk_out` toggles once every (pre ratio × post ratio) events.
- R4: On the high-frequency path, pre-divider codes 0 to 6 give a pre ratio of 1, 2, 4, 8, 16, 32 and 64. Code 7 gives a pre ratio of 122.
- R5: With select 0, the pre-divider code has no effect and the pre ratio is 1.
- R6: A post-divider code n gives a post ratio of 2 to the power n.
- R7: While the enable bit is 0, `clk_out` is held low from the next cycle on and the counters stay clear. After the enable bit is set, counting starts from zero.
- R8: While the output is enabled, a written change of the codes or the select takes effect only at the clock edge where `clk_out` falls. A high phase in progress keeps the length set by the configuration it started with.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; both references are sampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| lf_clk_i | input | 1 | 32768 Hz reference, asynchronous |
| hf_clk_i | input | 1 | High-frequency reference, asynchronous |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents |
| clk_out | output | 1 | Divided, gated clock output |

## Verification
The bench builds the block with the default synchronizer depth of two stages and uses the same depth in its behavioural model. Events therefore appear two cycles after each reference edge. The high-frequency reference toggles on every bench cycle, which gives one event per cycle. Even the largest total ratio of 122 × 128 can then be measured as a high phase of 15616 cycles within the run. The low-frequency reference toggles every five cycles, slow enough to show the pre-divider being bypassed at several post ratios.

// File: rtl/cod_pkg.sv
// Package: shared field positions, counter widths and the pre-divider
// ratio decode for the clock output divider.
// Assumes: an 8-bit control register with three-bit divider codes.
package cod_pkg;
    localparam int CFG_W         = 8;
    localparam int CODE_W        = 3;
    localparam int EN_BIT        = 0;
    localparam int POST_LSB      = 1;
    localparam int SEL_BIT       = 4;
    localparam int PRE_LSB       = 5;
    localparam int PRE_TOP_RATIO = 122;
    localparam int PRE_CNT_W     = $clog2(PRE_TOP_RATIO);
    localparam int POST_CNT_W    = (1 << CODE_W) - 1;

    // Divider settings that the counters currently run with
    typedef struct packed {
        logic [CODE_W-1:0] pre;
        logic              sel;
        logic [CODE_W-1:0] post;
    } cod_live_t;

    // Last count value of the pre-divider for a given code
    function automatic logic [PRE_CNT_W-1:0] pre_last(input logic [CODE_W-1:0] code);
        if (code == CODE_W'((1 << CODE_W) - 1))
            return PRE_CNT_W'(PRE_TOP_RATIO - 1);
        else
            return PRE_CNT_W'((1 << code) - 1);
    endfunction

    // Last count value of the post-divider for a given code
    function automatic logic [POST_CNT_W-1:0] post_last(input logic [CODE_W-1:0] code);
        return POST_CNT_W'((1 << code) - 1);
    endfunction

    // Extract the divider settings from a control register value
    function automatic cod_live_t cfg_fields(input logic [CFG_W-1:0] cfg);
        cod_live_t f;
        f.pre  = cfg[PRE_LSB +: CODE_W];
        f.sel  = cfg[SEL_BIT];
        f.post = cfg[POST_LSB +: CODE_W];
        return f;
    endfunction
endpackage

// File: rtl/cod_edge_sync.sv
// Module: brings one asynchronous reference clock into the block clock
// domain through a flop chain. It emits a one-cycle event for every
// rising or falling edge seen at the end of the chain.
// Assumes: the reference is slower than half the block clock.
module cod_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic event_o
);
    logic [STAGES-1:0] chain_q;
    logic              hist_q;

    generate
        if (STAGES == 1) begin : g_one
            // Single capture flop
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= ref_i;
            end
        end else begin : g_many
            // Shift the reference through the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], ref_i};
            end
        end
    endgenerate

    // Keep the previous synchronized value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= 1'b0;
        else        hist_q <= chain_q[STAGES-1];
    end

    assign event_o = chain_q[STAGES-1] ^ hist_q;
endmodule

// File: rtl/cod_prediv.sv
// Module: pre-divider of the high-frequency path. It passes one strobe
// for every pre-ratio events; in bypass it passes every event.
// Assumes: clr is raised whenever the code may change while the count is
// not zero.
module cod_prediv
    import cod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bypass,
    input  logic [CODE_W-1:0] code,
    input  logic              event_i,
    output logic              strobe_o
);
    logic [PRE_CNT_W-1:0] cnt_q;
    logic [PRE_CNT_W-1:0] last;
    logic                 hit;

    assign last     = pre_last(code);
    assign hit      = (cnt_q == last);
    assign strobe_o = event_i && (bypass || hit);

    // Count events up to the pre ratio, wrapping at the last value
    always_ff @(posedge clk) begin
        if (!rst_n || clr)          cnt_q <= '0;
        else if (event_i && !bypass) cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end

    // R4
    pre_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last);

    // R5
    pre_bypass_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && $past(bypass)) |-> (cnt_q == '0));
endmodule

// File: rtl/cod_postdiv.sv
// Module: power-of-two post-divider. It counts pre-divider strobes and
// raises a toggle request on the last strobe of each half period.
// Assumes: the code changes only when the counter has just been cleared.
module cod_postdiv
    import cod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [CODE_W-1:0] code,
    input  logic              strobe_i,
    output logic              wrap_o
);
    logic [POST_CNT_W-1:0] cnt_q;
    logic [POST_CNT_W-1:0] last;
    logic                  hit;

    assign last   = post_last(code);
    assign hit    = (cnt_q == last);
    assign wrap_o = strobe_i && hit;

    // Count strobes up to the post ratio, wrapping at the last value
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (strobe_i) cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end

    // R6
    post_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last);
endmodule

// File: rtl/clkout_divider.sv
// Module: top of the selectable clock output divider. It holds the
// control register, synchronizes both references, chains the pre- and
// post-dividers and toggles the output. New settings move to the counters
// only while disabled or at a falling output edge.
// Assumes: references are far slower than clk; the register port is
// synchronous to clk.
module clkout_divider
    import cod_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lf_clk_i,
    input  logic             hf_clk_i,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             clk_out
);
    localparam int NUM_REFS = 2;

    logic [CFG_W-1:0]    ctrl_q;
    cod_live_t           live_q;
    logic                out_q;
    logic                en;
    logic [NUM_REFS-1:0] ref_in;
    logic [NUM_REFS-1:0] ref_ev;
    logic                ev_sel;
    logic                pre_strobe;
    logic                post_wrap;

    // Control register write port
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (cfg_we) ctrl_q <= cfg_wdata;
    end

    assign cfg_rdata = ctrl_q;
    assign en        = ctrl_q[EN_BIT];
    assign ref_in    = {hf_clk_i, lf_clk_i};

    generate
        for (genvar g = 0; g < NUM_REFS; g++) begin : g_sync
            cod_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk     (clk),
                .rst_n   (rst_n),
                .ref_i   (ref_in[g]),
                .event_o (ref_ev[g])
            );
        end
    endgenerate

    assign ev_sel = live_q.sel ? ref_ev[1] : ref_ev[0];

    cod_prediv u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!en),
        .bypass   (!live_q.sel),
        .code     (live_q.pre),
        .event_i  (ev_sel),
        .strobe_o (pre_strobe)
    );

    cod_postdiv u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!en),
        .code     (live_q.post),
        .strobe_i (pre_strobe),
        .wrap_o   (post_wrap)
    );

    // Output toggle and deferred loading of the divider settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= 1'b0;
            live_q <= '0;
        end else if (!en) begin
            out_q  <= 1'b0;
            live_q <= cfg_fields(ctrl_q);
        end else if (post_wrap) begin
            out_q <= !out_q;
            if (out_q) live_q <= cfg_fields(ctrl_q);
        end
    end

    assign clk_out = out_q;

    // R1
    cfg_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata == $past(cfg_wdata)));

    // R7
    en_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !clk_out);

    // R8
    live_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_out |=> (!clk_out || $stable(live_q)));

    // R3
    rise_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_out) |-> $past(ev_sel));
endmodule

// File: tb/sim_clkout_divider.sv
// Bench: behavioural reference model of the divider, compared with the
// design on every clock, plus measured high-phase lengths.
module sim_clkout_divider;
    localparam int SYNC   = 2;
    localparam int LFHALF = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lf_clk_i = 1'b0;
    logic       hf_clk_i = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       clk_out;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string cur_req = "R2";

    clkout_divider #(.SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .lf_clk_i(lf_clk_i), .hf_clk_i(hf_clk_i),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .clk_out(clk_out)
    );

    always #4 clk = ~clk;

    // Reference clock generators, changed away from the sampling edge
    int lf_div = 0;
    always @(negedge clk) begin
        hf_clk_i <= rst_n ? ~hf_clk_i : 1'b0;
        if (!rst_n) begin
            lf_div = 0;
            lf_clk_i <= 1'b0;
        end else begin
            lf_div = lf_div + 1;
            if (lf_div == LFHALF) begin
                lf_div = 0;
                lf_clk_i <= ~lf_clk_i;
            end
        end
    end

    function automatic int pre_ratio(input int code);
        return (code == 7) ? 122 : (1 << code);
    endfunction

    // Behavioural model state
    logic [7:0]    m_ctrl = 8'h00;
    logic [SYNC:0] m_lfh = '0;
    logic [SYNC:0] m_hfh = '0;
    int            m_cnt = 0;
    bit            m_out = 1'b0;
    int            m_pre = 0, m_post = 0;
    bit            m_sel = 1'b0;

    always @(posedge clk) begin
        logic [7:0] old;
        bit e_lf, e_hf, ev;
        int ratio;
        cyc = cyc + 1;
        if (!rst_n) begin
            m_ctrl = 0; m_lfh = 0; m_hfh = 0; m_cnt = 0; m_out = 0;
            m_pre = 0; m_post = 0; m_sel = 0;
        end else begin
            e_lf  = m_lfh[SYNC] ^ m_lfh[SYNC-1];
            e_hf  = m_hfh[SYNC] ^ m_hfh[SYNC-1];
            m_lfh = {m_lfh[SYNC-1:0], lf_clk_i};
            m_hfh = {m_hfh[SYNC-1:0], hf_clk_i};
            old = m_ctrl;
            if (cfg_we) m_ctrl = cfg_wdata;
            if (!old[0]) begin
                m_out = 0; m_cnt = 0;
                m_pre = int'(old[7:5]); m_post = int'(old[3:1]); m_sel = old[4];
            end else begin
                ev = m_sel ? e_hf : e_lf;
                ratio = (m_sel ? pre_ratio(m_pre) : 1) * (1 << m_post);
                if (ev) begin
                    m_cnt = m_cnt + 1;
                    if (m_cnt == ratio) begin
                        m_cnt = 0;
                        if (m_out) begin
                            m_pre = int'(old[7:5]); m_post = int'(old[3:1]); m_sel = old[4];
                        end
                        m_out = !m_out;
                    end
                end
            end
        end
    end

    // Every-cycle comparison against the model
    always @(posedge clk) begin
        #2;
        if (!done) begin
            n_cmp = n_cmp + 1;
            if (clk_out !== m_out || cfg_rdata !== m_ctrl) begin
                n_bad = n_bad + 1;
                $display("FAIL %s: cycle %0d out=%b rdata=%h expected out=%b rdata=%h",
                         cur_req, cyc, clk_out, cfg_rdata, m_out, m_ctrl);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp = n_cmp + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic sample();
        @(posedge clk); #2;
    endtask

    task automatic wait_level(input bit lvl);
        do sample(); while (clk_out !== lvl);
    endtask

    // Let the pending configuration load, then measure one high phase
    task automatic measure_high(input string req, input int exp);
        int t0;
        wait_level(1'b1);
        wait_level(1'b0);
        wait_level(1'b1);
        t0 = cyc;
        wait_level(1'b0);
        check(req, cyc - t0, exp);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 190000);
        n_cmp = n_cmp + 1;
        n_bad = n_bad + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int t0;
        repeat (4) sample();
        // R2 reset state
        check("R2", int'(clk_out), 0);
        check("R2", int'(cfg_rdata), 0);
        @(negedge clk); rst_n = 1'b1;

        // R1 readback with enable off; R7 output stays low
        cur_req = "R1";
        write_cfg(8'hA4);
        sample();
        check("R1", int'(cfg_rdata), 8'hA4);
        cur_req = "R7";
        repeat (40) begin
            sample();
            check("R7", int'(clk_out), 0);
        end

        // R3 low-frequency path, post ratio 1: high phase of one event
        cur_req = "R3";
        write_cfg(8'h01);
        measure_high("R3", LFHALF);

        // R5 pre code 7 ignored on low-frequency path, post code 2
        cur_req = "R5";
        write_cfg(8'hE5);
        check("R1", int'(cfg_rdata), 8'hE5);
        measure_high("R5", 4 * LFHALF);

        // R4 each pre code on the high-frequency path, post code 0
        cur_req = "R4";
        for (int p = 0; p < 8; p++) begin
            write_cfg(8'((p << 5) | 8'h11));
            measure_high("R4", pre_ratio(p));
        end

        // R6 each post code with pre code 1
        cur_req = "R6";
        for (int q = 0; q < 8; q++) begin
            write_cfg(8'(8'h31 | (q << 1)));
            measure_high("R6", 2 * (1 << q));
        end

        // R8 change written during a high phase is deferred
        cur_req = "R8";
        write_cfg(8'h75);
        measure_high("R8", 32);
        wait_level(1'b1);
        t0 = cyc;
        repeat (3) sample();
        write_cfg(8'h11);
        wait_level(1'b0);
        check("R8", cyc - t0, 32);
        measure_high("R8", 1);

        // R7 disable during a high phase forces the output low
        cur_req = "R7";
        write_cfg(8'h75);
        wait_level(1'b1);
        write_cfg(8'h74);
        sample();
        check("R7", int'(clk_out), 0);
        repeat (20) begin
            sample();
            check("R7", int'(clk_out), 0);
        end

        // R4 largest total ratio, 122 x 128
        cur_req = "R4";
        write_cfg(8'hFF);
        measure_high("R4", 122 * 128);

        finish_run();
    end
endmodule